// File: doc/BRIEF.md
# Flash Encryption Job Lifecycle Controller

This block is the register front end and lifecycle sequencer for a manual flash-encryption engine. Software uses a 32-bit register bus to load a plaintext line buffer of up to eight words, choose a line width of 16 or 32 bytes, and set a 30-bit physical flash address. It then issues command writes. An accepted trigger hands the line, the address and the width to an external cipher datapath as a one-cycle start pulse. The controller then waits for that datapath's done pulse.

Each computed line moves through four states: idle, working, computed but hidden, and in use. The encrypted line reaches the flash controller only after software writes the release command. A destroy command drops the job from any state and wipes the plaintext buffer. A trigger whose address is not aligned to the chosen line width starts nothing and raises a sticky error flag.

Top module: `fenc_lifecycle_ctrl`

## Requirements
- R1: After reset the register reads are as follows. Status (offset 0x58) reads 0, meaning idle. Line size (0x40), destination (0x44), physical address (0x48) and every buffer word read 0. The version register (0x5C) reads 0x20200623. The outputs `ciph_start`, `fl_visible` and `cfg_err` are low.
- R2: The following registers read back what was written. Line size is bit 0, where 1 selects a 32-byte line. Destination is bit 0. The physical address is bits 29:0. The version is bits 29:0. Buffer word n is at offset 4*n for n from 0 to 7. Unused bits read 0. The trigger (0x4C), release (0x50) and destroy (0x54) offsets read 0.
- R3: A write with bit 0 set to the trigger offset has the following effect when the state is idle and the address is aligned. The state becomes 1 (working) at the next clock. `ciph_start` is high for exactly one cycle, with `ciph_line`, `ciph_addr` and `ciph_wide` carrying the job.
- R4: Alignment means the low 5 address bits are zero for a 32-byte line and the low 4 bits are zero for a 16-byte line. A trigger on a misaligned address leaves the state idle and raises no start. It sets `cfg_err`, which also reads as status bit 2. The flag stays set until destroy.
- R5: A `ciph_done` pulse while working moves the state to 2 (computed, hidden). In that state `fl_visible` is low and `fl_line` and `fl_addr` are zero.
- R6: A release write while hidden moves the state to 3 (in use). `fl_visible` then goes high, `fl_line` carries the result captured at done, and `fl_addr` carries the job address. For a 16-byte job, words 4 to 7 of `fl_line` (bits 255:128) are zero.
- R7: A trigger in any state other than idle, and a release in any state other than hidden, leave the state and the outputs unchanged.
- R8: While working, writes to the buffer, line size, destination, address and version are ignored.
- R9: A destroy write returns the state to idle from any state, clears every buffer word to 0, clears `cfg_err` and removes visibility.
- R10: When destroy and `ciph_done` arrive in the same cycle while working, destroy wins. The state becomes idle and the result never becomes visible.
- R11: A `ciph_done` pulse outside the working state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ciph_start | output | 1 | One-cycle job start to the cipher |
| ciph_wide | output | 1 | Job uses a 32-byte line |
| ciph_addr | output | 30 | Job physical address |
| ciph_line | output | 256 | Plaintext line, word 0 in bits 31:0 |
| ciph_done | input | 1 | Cipher finished pulse |
| ciph_result | input | 256 | Cipher output line |
| fl_visible | output | 1 | Result released to the flash controller |
| fl_wide | output | 1 | Width of the visible line |
| fl_addr | output | 30 | Address of the visible line, zero when hidden |
| fl_line | output | 256 | Visible encrypted line, zero when hidden |
| cfg_err | output | 1 | Sticky misaligned-trigger flag |

## Verification
The contested cycle is the one in which the cipher's done pulse and a software destroy write reach the controller at the same clock edge. The bench provokes it by taking manual control of the cipher stand-in and driving done in the same cycle that the bus presents the destroy write. It judges the outcome at the ports. The status must read idle. A following release must leave `fl_visible` low. The buffer must read zero. A second overlap, command writes and configuration writes arriving while a job is running, is judged by reading the configuration back and comparing the released line against the plaintext that was loaded before the trigger.

// File: rtl/fenc_pkg.sv
// Shared types and register offsets for the flash encryption lifecycle controller.
package fenc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WORK    = 2'd1,
        ST_RELEASE = 2'd2,
        ST_USE     = 2'd3
    } fenc_state_e;

    localparam logic [7:0] OFS_LSIZE   = 8'h40;
    localparam logic [7:0] OFS_DEST    = 8'h44;
    localparam logic [7:0] OFS_PADDR   = 8'h48;
    localparam logic [7:0] OFS_TRIG    = 8'h4C;
    localparam logic [7:0] OFS_REL     = 8'h50;
    localparam logic [7:0] OFS_DESTROY = 8'h54;
    localparam logic [7:0] OFS_STATUS  = 8'h58;
    localparam logic [7:0] OFS_VER     = 8'h5C;
endpackage

// File: rtl/fenc_regfile.sv
// Register storage: plaintext line buffer, line size, destination, address, version.
// Assumes one bus access per cycle; decodes command offsets into single-cycle pulses.
// cfg_lock blocks data and configuration writes; wipe clears the line buffer.
module fenc_regfile
    import fenc_pkg::*;
#(
    parameter int DW      = 32,
    parameter int WORDS   = 8,
    parameter int AW      = 30,
    parameter int VER_W   = 30,
    parameter logic [VER_W-1:0] VER_RST = 30'h20200623
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [7:0]          addr,
    input  logic [DW-1:0]       wdata,
    input  logic                cfg_lock,
    input  logic                wipe,
    output logic [DW*WORDS-1:0] buf_flat,
    output logic                lsize,
    output logic                dest,
    output logic [AW-1:0]       paddr,
    output logic [VER_W-1:0]    version,
    output logic                cmd_trig,
    output logic                cmd_rel,
    output logic                cmd_destroy
);
    localparam int IDX_W = 4;

    logic          wr_ok;
    logic          in_buf;
    logic [IDX_W-1:0] widx;

    assign wr_ok  = wr && !cfg_lock;
    assign in_buf = (addr < OFS_LSIZE);
    assign widx   = addr[5:2];

    // Command strobes: write of bit 0 to a command offset.
    assign cmd_trig    = wr && (addr == OFS_TRIG)    && wdata[0];
    assign cmd_rel     = wr && (addr == OFS_REL)     && wdata[0];
    assign cmd_destroy = wr && (addr == OFS_DESTROY) && wdata[0];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Holds one plaintext word; cleared on reset or wipe.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                buf_flat[i*DW +: DW] <= '0;
            else if (wr_ok && in_buf && (widx == IDX_W'(i)))
                buf_flat[i*DW +: DW] <= wdata;
        end
    end

    // Holds the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsize   <= 1'b0;
            dest    <= 1'b0;
            paddr   <= '0;
            version <= VER_RST;
        end else if (wr_ok) begin
            if (addr == OFS_LSIZE) lsize   <= wdata[0];
            if (addr == OFS_DEST)  dest    <= wdata[0];
            if (addr == OFS_PADDR) paddr   <= wdata[AW-1:0];
            if (addr == OFS_VER)   version <= wdata[VER_W-1:0];
        end
    end

    // R8: configuration is frozen while a job runs.
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> ($stable(paddr) && $stable(lsize) && $stable(dest) && $stable(version)));
    // R9: a wipe leaves the first buffer word cleared.
    a_r9_wipe_buf: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (buf_flat[DW-1:0] == '0));
endmodule

// File: rtl/fenc_fsm.sv
// Job lifecycle sequencer: idle -> working -> hidden -> in use, destroy returns to idle.
// Checks address alignment at trigger, latches the job address and width, and
// issues a one-cycle start. Destroy has priority over every other event.
module fenc_fsm
    import fenc_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_trig,
    input  logic          cmd_rel,
    input  logic          cmd_destroy,
    input  logic          lsize,
    input  logic [AW-1:0] paddr,
    input  logic          done,
    output fenc_state_e   state,
    output logic          err,
    output logic          start,
    output logic          job_wide,
    output logic [AW-1:0] job_addr,
    output logic          cap,
    output logic          cfg_lock
);
    logic aligned;

    assign aligned  = lsize ? (paddr[4:0] == 5'd0) : (paddr[3:0] == 4'd0);
    assign cap      = (state == ST_WORK) && done && !cmd_destroy;
    assign cfg_lock = (state == ST_WORK);

    // Advances the lifecycle and captures the job parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            err      <= 1'b0;
            start    <= 1'b0;
            job_wide <= 1'b0;
            job_addr <= '0;
        end else begin
            start <= 1'b0;
            if (cmd_destroy) begin
                state <= ST_IDLE;
                err   <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: if (cmd_trig) begin
                        if (aligned) begin
                            state    <= ST_WORK;
                            start    <= 1'b1;
                            job_addr <= paddr;
                            job_wide <= lsize;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                    ST_WORK:    if (done)    state <= ST_RELEASE;
                    ST_RELEASE: if (cmd_rel) state <= ST_USE;
                    ST_USE:     ;
                endcase
            end
        end
    end

    // R3: an accepted trigger enters working.
    a_r3_trig_to_work: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_trig && state == ST_IDLE && aligned && !cmd_destroy) |=> (state == ST_WORK && start));
    // R3: start lasts one cycle.
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R4: the error flag is sticky until destroy.
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !cmd_destroy) |=> err);
    // R7: release outside the hidden state changes nothing.
    a_r7_rel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rel && (state == ST_IDLE || state == ST_USE)) |=> $stable(state));
    // R9, R10: destroy always lands in idle with the flag clear.
    a_r9_destroy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_destroy |=> (state == ST_IDLE && !err && !start));
    // R11: done in idle does not leave idle.
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state == ST_IDLE && !cmd_trig) |=> (state == ST_IDLE));
endmodule

// File: rtl/fenc_result.sv
// Result store and visibility gate. Captures the cipher output on cap, zeroing the
// upper half of the line for narrow jobs; shows it only while show is high.
module fenc_result #(
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic                wipe,
    input  logic                wide,
    input  logic                show,
    input  logic [DW*WORDS-1:0] din,
    output logic [DW*WORDS-1:0] dout
);
    localparam int HALF = WORDS / 2;

    logic [DW*WORDS-1:0] store;

    for (genvar i = 0; i < WORDS; i++) begin : g_res
        if (i < HALF) begin : g_lo
            // Captures a lower-half word for every job width.
            always_ff @(posedge clk) begin
                if (!rst_n || wipe)   store[i*DW +: DW] <= '0;
                else if (cap)         store[i*DW +: DW] <= din[i*DW +: DW];
            end
        end else begin : g_hi
            // Captures an upper-half word only for wide jobs.
            always_ff @(posedge clk) begin
                if (!rst_n || wipe)   store[i*DW +: DW] <= '0;
                else if (cap)         store[i*DW +: DW] <= wide ? din[i*DW +: DW] : '0;
            end
        end
    end

    assign dout = show ? store : '0;
endmodule

// File: rtl/fenc_lifecycle_ctrl.sv
// Top of the flash encryption lifecycle controller: register file, lifecycle
// sequencer and gated result store, plus the combinational register read mux.
// Assumes one register access per cycle and a single-cycle ciph_done pulse.
module fenc_lifecycle_ctrl
    import fenc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = 8,
    parameter int AW    = 30,
    parameter int VER_W = 30,
    parameter logic [VER_W-1:0] VER_RST = 30'h20200623,
    localparam int LINE_W = DW * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              ciph_start,
    output logic              ciph_wide,
    output logic [AW-1:0]     ciph_addr,
    output logic [LINE_W-1:0] ciph_line,
    input  logic              ciph_done,
    input  logic [LINE_W-1:0] ciph_result,
    output logic              fl_visible,
    output logic              fl_wide,
    output logic [AW-1:0]     fl_addr,
    output logic [LINE_W-1:0] fl_line,
    output logic              cfg_err
);
    logic [LINE_W-1:0] buf_flat;
    logic              lsize, dest;
    logic [AW-1:0]     paddr, job_addr;
    logic [VER_W-1:0]  version;
    logic              cmd_trig, cmd_rel, cmd_destroy;
    logic              cap, cfg_lock, job_wide;
    fenc_state_e       state;
    logic [3:0]        ridx;

    fenc_regfile #(.DW(DW), .WORDS(WORDS), .AW(AW), .VER_W(VER_W), .VER_RST(VER_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cfg_lock(cfg_lock), .wipe(cmd_destroy), .buf_flat(buf_flat), .lsize(lsize),
        .dest(dest), .paddr(paddr), .version(version), .cmd_trig(cmd_trig),
        .cmd_rel(cmd_rel), .cmd_destroy(cmd_destroy)
    );

    fenc_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_trig(cmd_trig), .cmd_rel(cmd_rel),
        .cmd_destroy(cmd_destroy), .lsize(lsize), .paddr(paddr), .done(ciph_done),
        .state(state), .err(cfg_err), .start(ciph_start), .job_wide(job_wide),
        .job_addr(job_addr), .cap(cap), .cfg_lock(cfg_lock)
    );

    fenc_result #(.DW(DW), .WORDS(WORDS)) u_res (
        .clk(clk), .rst_n(rst_n), .cap(cap), .wipe(cmd_destroy), .wide(job_wide),
        .show(fl_visible), .din(ciph_result), .dout(fl_line)
    );

    assign ciph_line  = buf_flat;
    assign ciph_addr  = job_addr;
    assign ciph_wide  = job_wide;
    assign fl_visible = (state == ST_USE);
    assign fl_wide    = fl_visible && job_wide;
    assign fl_addr    = fl_visible ? job_addr : '0;
    assign ridx       = bus_addr[5:2];

    // Selects read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < OFS_LSIZE) begin
            if (32'(ridx) < WORDS) bus_rdata = buf_flat[32'(ridx)*DW +: DW];
        end else begin
            case (bus_addr)
                OFS_LSIZE:  bus_rdata[0]       = lsize;
                OFS_DEST:   bus_rdata[0]       = dest;
                OFS_PADDR:  bus_rdata[AW-1:0]  = paddr;
                OFS_STATUS: bus_rdata[2:0]     = {cfg_err, state};
                OFS_VER:    bus_rdata[VER_W-1:0] = version;
                default:    bus_rdata          = '0;
            endcase
        end
    end

    // R5: a computed line stays hidden before release.
    a_r5_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE) |-> (!fl_visible && fl_line == '0 && fl_addr == '0));
    // R6: release from the hidden state exposes the line.
    a_r6_release_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && cmd_rel && !cmd_destroy) |=> fl_visible);
    // R10: done coinciding with destroy never exposes a result.
    a_r10_destroy_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ciph_done && cmd_destroy) |=> (!fl_visible && state == ST_IDLE));
endmodule

// File: tb/fenc_lifecycle_ctrl_tb.sv
// Scoreboard bench: jobs push expected released lines into a queue; a monitor
// pops and compares them when fl_visible rises.
module fenc_lifecycle_ctrl_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = 5;
    localparam logic [255:0] KEY = {8{32'h5A3C_E187}} ^ {4{64'h0F1E_2D3C_4B5A_6978}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         ciph_start, ciph_wide, ciph_done;
    logic [29:0]  ciph_addr, fl_addr;
    logic [255:0] ciph_line, ciph_result, fl_line;
    logic         fl_visible, fl_wide, cfg_err;

    logic         auto_ciph = 1'b1;
    logic         sd_done = 1'b0;
    logic [255:0] sd_res = '0;
    logic         man_done = 1'b0;
    logic [255:0] man_res = '0;
    int           sd_cnt = 0;
    logic         sd_busy = 1'b0;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [255:0] exp_q[$];
    logic [29:0]  exp_a[$];
    logic         prev_vis = 1'b0;

    assign ciph_done   = sd_done | man_done;
    assign ciph_result = sd_done ? sd_res : man_res;

    always #5 clk = ~clk;

    fenc_lifecycle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ciph_start(ciph_start),
        .ciph_wide(ciph_wide), .ciph_addr(ciph_addr), .ciph_line(ciph_line),
        .ciph_done(ciph_done), .ciph_result(ciph_result), .fl_visible(fl_visible),
        .fl_wide(fl_wide), .fl_addr(fl_addr), .fl_line(fl_line), .cfg_err(cfg_err)
    );

    function automatic logic [255:0] enc(input logic [255:0] line, input logic [29:0] a);
        return line ^ KEY ^ {8{2'b00, a}};
    endfunction

    // Keyed cipher stand-in with fixed latency.
    always @(negedge clk) begin
        sd_done <= 1'b0;
        if (auto_ciph && ciph_start) begin
            sd_res  <= enc(ciph_line, ciph_addr);
            sd_cnt  <= LAT;
            sd_busy <= 1'b1;
        end else if (sd_busy) begin
            if (sd_cnt == 1) begin
                sd_done <= 1'b1;
                sd_busy <= 1'b0;
            end
            sd_cnt <= sd_cnt - 1;
        end
    end

    task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Monitor: on each release, pop and compare the expected line.
    always @(negedge clk) begin
        if (rst_n && fl_visible && !prev_vis) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected release", 256'(fl_visible), 256'(0));
            end else begin
                check("R6 released line", fl_line, exp_q.pop_front());
                check("R6 released address", 256'(fl_addr), 256'(exp_a.pop_front()));
            end
        end
        prev_vis <= fl_visible;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, 256'(d), 256'(exp));
    endtask

    task automatic wait_state(input logic [1:0] s);
        logic [31:0] d;
        for (int i = 0; i < 100; i++) begin
            rd(8'h58, d);
            if (d[1:0] == s) break;
        end
    endtask

    task automatic load_line(input logic [255:0] line);
        for (int i = 0; i < 8; i++) wr(8'(4 * i), line[i*32 +: 32]);
    endtask

    function automatic logic [255:0] narrow(input logic [255:0] v);
        return {128'b0, v[127:0]};
    endfunction

    initial begin
        #500000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] line_a, line_b;
        logic [31:0] d;
        line_a = {32'h8877_6655, 32'h7766_5544, 32'h6655_4433, 32'h5544_3322,
                  32'h4433_2211, 32'h3322_1100, 32'h2211_00FF, 32'h1100_FFEE};
        line_b = {32'hCAFE_0007, 32'hCAFE_0006, 32'hCAFE_0005, 32'hCAFE_0004,
                  32'hCAFE_0003, 32'hCAFE_0002, 32'hCAFE_0001, 32'hCAFE_0000};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 status", 8'h58, 32'h0);
        rd_check("R1 version", 8'h5C, 32'h2020_0623);
        rd_check("R1 line size", 8'h40, 32'h0);
        rd_check("R1 destination", 8'h44, 32'h0);
        rd_check("R1 address", 8'h48, 32'h0);
        rd_check("R1 buffer word 3", 8'h0C, 32'h0);
        check("R1 outputs", 256'({ciph_start, fl_visible, cfg_err}), 256'(0));

        // R2 readback
        wr(8'h40, 32'hFFFF_FFFF); rd_check("R2 line size", 8'h40, 32'h1);
        wr(8'h44, 32'hFFFF_FFFF); rd_check("R2 destination", 8'h44, 32'h1);
        wr(8'h48, 32'hFFFF_FFFF); rd_check("R2 address", 8'h48, 32'h3FFF_FFFF);
        wr(8'h5C, 32'hC123_4567); rd_check("R2 version", 8'h5C, 32'h0123_4567);
        wr(8'h1C, 32'hA1B2_C3D4); rd_check("R2 buffer word 7", 8'h1C, 32'hA1B2_C3D4);
        rd_check("R2 trigger offset", 8'h4C, 32'h0);
        wr(8'h44, 32'h0);

        // Job A: wide, aligned
        load_line(line_a);
        wr(8'h40, 32'h1);
        wr(8'h48, 32'h0000_1000);
        exp_q.push_back(enc(line_a, 30'h1000)); exp_a.push_back(30'h1000);
        wr(8'h4C, 32'h1);
        check("R3 start pulse", 256'(ciph_start), 256'(1));
        check("R3 start address", 256'(ciph_addr), 256'(30'h1000));
        check("R3 start line", ciph_line, line_a);
        rd_check("R3 state working", 8'h58, 32'h1);
        check("R3 start ends", 256'(ciph_start), 256'(0));
        wr(8'h00, 32'hDEAD_BEEF);   // R8 during work
        wr(8'h48, 32'h0000_2000);
        wr(8'h4C, 32'h1);           // R7 trigger while busy
        wait_state(2'd2);
        rd_check("R5 state hidden", 8'h58, 32'h2);
        check("R5 hidden line", fl_line, 256'(0));
        check("R5 not visible", 256'({fl_visible, fl_addr}), 256'(0));
        rd_check("R8 buffer kept", 8'h00, line_a[31:0]);
        rd_check("R8 address kept", 8'h48, 32'h0000_1000);
        wr(8'h50, 32'h1);
        rd_check("R6 state use", 8'h58, 32'h3);
        check("R6 wide flag", 256'(fl_wide), 256'(1));
        wr(8'h4C, 32'h1);           // R7 trigger in use
        wr(8'h50, 32'h1);           // R7 release in use
        rd_check("R7 still in use", 8'h58, 32'h3);
        check("R7 no restart", 256'(ciph_start), 256'(0));

        // R9 destroy
        wr(8'h54, 32'h1);
        rd_check("R9 idle after destroy", 8'h58, 32'h0);
        check("R9 visibility removed", 256'(fl_visible), 256'(0));
        rd_check("R9 buffer wiped", 8'h00, 32'h0);
        rd_check("R9 buffer top wiped", 8'h1C, 32'h0);

        // Job B: narrow, 16-byte aligned
        load_line(line_b);
        wr(8'h40, 32'h0);
        wr(8'h48, 32'h0000_1010);
        exp_q.push_back(narrow(enc(line_b, 30'h1010))); exp_a.push_back(30'h1010);
        wr(8'h4C, 32'h1);
        wr(8'h50, 32'h1);           // R7 release while working
        rd_check("R7 release ignored in work", 8'h58, 32'h1);
        wait_state(2'd2);
        wr(8'h50, 32'h1);
        check("R6 narrow upper half zero", 256'(fl_line[255:128]), 256'(0));
        check("R6 narrow width flag", 256'(fl_wide), 256'(0));
        wr(8'h54, 32'h1);

        // R4 misaligned trigger
        wr(8'h40, 32'h1);
        wr(8'h48, 32'h0000_1010);
        wr(8'h4C, 32'h1);
        check("R4 no start", 256'(ciph_start), 256'(0));
        check("R4 error flag", 256'(cfg_err), 256'(1));
        rd_check("R4 status idle with error", 8'h58, 32'h4);
        wr(8'h48, 32'h0000_1004);
        wr(8'h40, 32'h0);
        wr(8'h4C, 32'h1);
        rd_check("R4 sticky misaligned narrow", 8'h58, 32'h4);
        wr(8'h54, 32'h1);
        check("R9 error cleared", 256'(cfg_err), 256'(0));

        // R11 done while idle
        auto_ciph = 1'b0;
        @(negedge clk); man_done = 1'b1; man_res = {8{32'h1234_5678}};
        @(negedge clk); man_done = 1'b0;
        rd_check("R11 done ignored", 8'h58, 32'h0);
        wr(8'h50, 32'h1);
        check("R11 nothing visible", 256'(fl_visible), 256'(0));

        // R10 destroy and done in the same cycle
        load_line(line_a);
        wr(8'h48, 32'h0000_2000);
        wr(8'h4C, 32'h1);
        rd_check("R10 working", 8'h58, 32'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h54; bus_wdata = 32'h1;
        man_done = 1'b1; man_res = {8{32'hFEED_F00D}};
        @(negedge clk);
        bus_wr = 1'b0; man_done = 1'b0;
        rd_check("R10 destroy wins", 8'h58, 32'h0);
        wr(8'h50, 32'h1);
        check("R10 never visible", 256'(fl_visible), 256'(0));
        rd_check("R10 buffer wiped", 8'h04, 32'h0);

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", 256'(exp_q.size()), 256'(0));
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule